// File: doc/BRIEF.md
# Lockable Configurable Logic Array

This block turns groups of four general-purpose pins into small real-time combinational gates. Each group takes three pins as gate inputs and uses the fourth pin as the gate output. A group can act as any three-input function, given by an 8-entry truth table, or as a two-input XOR or XNOR. The gate path runs from the pad inputs to the pad outputs with no clock in it, so it keeps working whatever the register interface is doing. Pad levels stay visible on `pin_in`, so the gate inputs and the gate output can be read like any other port.

A group may cascade the output of the group below it into its own input 0. This forms a two-level gate. Each lower group can either drive its intermediate term onto its own output pin or leave that pin to ordinary GPIO use. Gate inputs that the selected function does not depend on go back to the GPIO path, and so does a pin freed by cascading.

Software sets up the block through one enable register and one function register per group. A write-once lock register freezes a group's enable bit and function register. Only a power-on reset clears the lock. The external reset also clears it, but only when a permission bit in the enable register is set.

Top module: `lockable_logic_array`

## Requirements
- R1: After power-on reset, every register reads 0 and every pin follows the GPIO path: `pin_out` equals `gpio_out` and `pin_oe` equals `gpio_oe`.
- R2: In table mode (function bits [9:8] = 00 or 11), an enabled group drives pin 4g+3 with `oe`=1 and value tt[{in2,in1,in0}]. The truth table is held in function bits [7:0], and input i is pin 4g+i. The output follows `pin_in` in the same cycle.
- R3: Mode 01 gives in0 XOR in1, and mode 10 gives in0 XNOR in1. Input 2 has no effect on the result in either mode.
- R4: In an enabled group, each gate input that the function depends on has its `pin_oe` forced to 0. In the XOR and XNOR modes this is inputs 0 and 1. Inputs the function ignores follow `gpio_oe` and `gpio_out`.
- R5: When function bit 10 (cascade) is set for group g>0, and groups g and g-1 are both enabled, input 0 of group g is the gate value of group g-1. Pin 4g then returns to GPIO use.
- R6: A group whose value feeds the group above it drives its output pin only when its own function bit 11 (intermediate output) is set. Otherwise that pin follows GPIO.
- R7: Register map: address 0 is the enable register (bit g enables group g; bit 11 allows the external reset to clear the lock). Address 1 is the lock register. Address 2+g is the function register of group g. A write takes effect at the next clock edge, and `rd_data` shows the addressed register combinationally.
- R8: While lock bit g is 1, writes leave enable bit g and function register g unchanged. Other bits and other registers can still be written.
- R9: Only the first write to the lock register after it was last cleared is stored. Later writes are ignored.
- R10: `rst_n` low at a clock edge clears the lock register, and re-opens it for one write, only if enable bit 11 is 1. No other state changes.
- R11: `por_n` low clears all registers and the lock at once. Its release takes effect on the second clock edge.
- R12: A disabled group leaves all four of its pins on the GPIO path, whatever its function register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| rst_n | input | 1 | External reset, active low, sampled on the clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 12 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 12 | Read data of the addressed register |
| gpio_out | input | NUM_PORTS | Output values from the GPIO path |
| gpio_oe | input | NUM_PORTS | Output enables from the GPIO path |
| pin_in | input | NUM_PORTS | Pad input levels |
| pin_out | output | NUM_PORTS | Pad output values |
| pin_oe | output | NUM_PORTS | Pad output enables |

## Verification
Pin results are combinational, so each is due in the same cycle as the `pin_in` change that causes it. Register results are due one clock edge after the write strobe or the `rst_n` pulse. Power-on results are due two edges after `por_n` rises. The driver changes inputs at a falling edge and pushes the expected item. The monitor takes the item 1 ns later in that same low phase, so every check falls after exactly the edges the result needs and before the next rising edge.

// File: rtl/llarr_pkg.sv
package llarr_pkg;
  localparam int TT_W      = 8;
  localparam int CFG_W     = 12;
  localparam int ALLOW_BIT = 11;
  localparam int GRP_PINS  = 4;
  localparam int GATE_IN   = 3;
  localparam int FUNC_BASE = 2;

  typedef enum logic [1:0] {
    MODE_TABLE  = 2'b00,
    MODE_XOR    = 2'b01,
    MODE_XNOR   = 2'b10,
    MODE_TABLE2 = 2'b11
  } gate_mode_e;

  typedef struct packed {
    logic            ioe;
    logic            casc;
    gate_mode_e      mode;
    logic [TT_W-1:0] tt;
  } func_t;
endpackage

// File: rtl/llarr_rst_sync.sv
module llarr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/llarr_cfg_regs.sv
module llarr_cfg_regs
  import llarr_pkg::*;
#(
  parameter int NUM_GRP = 2,
  parameter int ADDR_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ext_rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CFG_W-1:0]         wr_data,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [CFG_W-1:0]         rd_data,
  output logic [NUM_GRP-1:0]       grp_en,
  output func_t [NUM_GRP-1:0]      grp_func
);
  localparam logic [ADDR_W-1:0] A_EN   = '0;
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(1);

  logic [NUM_GRP-1:0] en_q, en_d, lock_q, lock_d;
  logic               allow_q, allow_d, spent_q, spent_d;
  logic               en_ld, lock_ld, clr_lock;
  func_t [NUM_GRP-1:0] func_q, func_d;
  logic [NUM_GRP-1:0] func_ld;

  // next-state
  always_comb begin
    en_d     = en_q;
    allow_d  = allow_q;
    lock_d   = lock_q;
    spent_d  = spent_q;
    func_d   = func_q;
    func_ld  = '0;
    clr_lock = !ext_rst_n && allow_q;
    en_ld    = wr_en && (wr_addr == A_EN);
    lock_ld  = clr_lock || (wr_en && (wr_addr == A_LOCK) && !spent_q);
    if (en_ld) begin
      allow_d = wr_data[ALLOW_BIT];
      for (int g = 0; g < NUM_GRP; g++) begin
        if (!lock_q[g]) en_d[g] = wr_data[g];
      end
    end
    if (clr_lock) begin
      lock_d  = '0;
      spent_d = 1'b0;
    end else if (lock_ld) begin
      lock_d  = wr_data[NUM_GRP-1:0];
      spent_d = 1'b1;
    end
    for (int g = 0; g < NUM_GRP; g++) begin
      if (wr_en && (wr_addr == ADDR_W'(FUNC_BASE + g)) && !lock_q[g]) begin
        func_ld[g] = 1'b1;
        func_d[g]  = func_t'(wr_data);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      allow_q <= 1'b0;
    end else if (en_ld) begin
      en_q    <= en_d;
      allow_q <= allow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= '0;
      spent_q <= 1'b0;
    end else if (lock_ld) begin
      lock_q  <= lock_d;
      spent_q <= spent_d;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_func
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          func_q[g] <= '0;
      else if (func_ld[g]) func_q[g] <= func_d[g];
    end

    assert_lock_freeze_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[g] |=> (en_q[g] == $past(en_q[g])));
    assert_lock_freeze_func_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q[g] |=> (func_q[g] == $past(func_q[g])));
    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q[g] && !(!ext_rst_n && allow_q)) |=> lock_q[g]);
  end

  assert_lock_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spent_q && ext_rst_n) |=> $stable(lock_q));

  // readback
  always_comb begin
    rd_data = '0;
    if (rd_addr == A_EN) begin
      rd_data[NUM_GRP-1:0] = en_q;
      rd_data[ALLOW_BIT]   = allow_q;
    end else if (rd_addr == A_LOCK) begin
      rd_data[NUM_GRP-1:0] = lock_q;
    end
    for (int g = 0; g < NUM_GRP; g++) begin
      if (rd_addr == ADDR_W'(FUNC_BASE + g)) rd_data = CFG_W'(func_q[g]);
    end
  end

  assign grp_en   = en_q;
  assign grp_func = func_q;
endmodule

// File: rtl/llarr_gate.sv
module llarr_gate
  import llarr_pkg::*;
(
  input  logic [GATE_IN-1:0] a,
  input  func_t              cfg,
  output logic               y,
  output logic [GATE_IN-1:0] used
);
  always_comb begin
    unique case (cfg.mode)
      MODE_XOR:  y = a[0] ^ a[1];
      MODE_XNOR: y = ~(a[0] ^ a[1]);
      default:   y = cfg.tt[a];
    endcase
  end

  // an input counts as used when flipping it changes some table entry
  always_comb begin
    used = '0;
    if (cfg.mode == MODE_XOR || cfg.mode == MODE_XNOR) begin
      used = 3'b011;
    end else begin
      for (int i = 0; i < GATE_IN; i++) begin
        for (int j = 0; j < TT_W; j++) begin
          if (cfg.tt[j] != cfg.tt[3'(j ^ (1 << i))]) used[i] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lockable_logic_array.sv
module lockable_logic_array
  import llarr_pkg::*;
#(
  parameter  int NUM_GRP   = 2,
  localparam int NUM_PORTS = NUM_GRP * GRP_PINS,
  localparam int ADDR_W    = $clog2(NUM_GRP + FUNC_BASE)
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CFG_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [CFG_W-1:0]     rd_data,
  input  logic [NUM_PORTS-1:0] gpio_out,
  input  logic [NUM_PORTS-1:0] gpio_oe,
  input  logic [NUM_PORTS-1:0] pin_in,
  output logic [NUM_PORTS-1:0] pin_out,
  output logic [NUM_PORTS-1:0] pin_oe
);
  logic                srst_n;
  logic [NUM_GRP-1:0]  grp_en, gy, casc_act, feeds_next, drive_out;
  func_t [NUM_GRP-1:0] grp_func;
  logic [NUM_GRP-1:0][GATE_IN-1:0] gin, gused, take;

  llarr_rst_sync u_rst (.clk(clk), .arst_n(por_n), .srst_n(srst_n));

  llarr_cfg_regs #(.NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(srst_n), .ext_rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .grp_en(grp_en), .grp_func(grp_func)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    localparam int B = g * GRP_PINS;

    if (g == 0) begin : g_first
      assign casc_act[g] = 1'b0;
      assign gin[g][0]   = pin_in[B];
    end else begin : g_chain
      assign casc_act[g] = grp_en[g] && grp_en[g-1] && grp_func[g].casc;
      assign gin[g][0]   = casc_act[g] ? gy[g-1] : pin_in[B];
    end

    if (g == NUM_GRP - 1) begin : g_top
      assign feeds_next[g] = 1'b0;
    end else begin : g_mid
      assign feeds_next[g] = grp_en[g+1] && grp_en[g] && grp_func[g+1].casc;
    end

    assign gin[g][2:1] = pin_in[B+2:B+1];

    llarr_gate u_gate (.a(gin[g]), .cfg(grp_func[g]), .y(gy[g]), .used(gused[g]));

    assign take[g]      = grp_en[g] ? (gused[g] & {2'b11, ~casc_act[g]}) : 3'b000;
    assign drive_out[g] = grp_en[g] && (!feeds_next[g] || grp_func[g].ioe);

    assert_disabled_passthru_R12: assert property (@(posedge clk) disable iff (!srst_n)
      !grp_en[g] |-> (pin_oe[B+3:B] == gpio_oe[B+3:B]) && (pin_out[B+3:B] == gpio_out[B+3:B]));
    assert_xor_out_R3: assert property (@(posedge clk) disable iff (!srst_n)
      (grp_en[g] && grp_func[g].mode == MODE_XOR && !casc_act[g] && drive_out[g])
        |-> pin_oe[B+3] && (pin_out[B+3] == (pin_in[B] ^ pin_in[B+1])));
    assert_casc_pin_free_R5: assert property (@(posedge clk) disable iff (!srst_n)
      casc_act[g] |-> (pin_oe[B] == gpio_oe[B]) && (pin_out[B] == gpio_out[B]));
    assert_hidden_mid_R6: assert property (@(posedge clk) disable iff (!srst_n)
      (feeds_next[g] && !grp_func[g].ioe) |-> (pin_oe[B+3] == gpio_oe[B+3]));
  end

  // pin multiplexing
  always_comb begin
    pin_out = gpio_out;
    pin_oe  = gpio_oe;
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int i = 0; i < GATE_IN; i++) begin
        if (take[g][i]) pin_oe[g*GRP_PINS + i] = 1'b0;
      end
      if (drive_out[g]) begin
        pin_out[g*GRP_PINS + 3] = gy[g];
        pin_oe[g*GRP_PINS + 3]  = 1'b1;
      end
    end
  end
endmodule

// File: tb/tb_lockable_logic_array.sv
module tb_lockable_logic_array;
  localparam int NG = 2;
  localparam int NP = 8;
  localparam int AW = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic por_n, rst_n, wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [11:0] wr_data, rd_data;
  logic [NP-1:0] gpio_out, gpio_oe, pin_in, pin_out, pin_oe;

  lockable_logic_array #(.NUM_GRP(NG)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .gpio_out(gpio_out),
    .gpio_oe(gpio_oe), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct {
    string         req;
    bit            is_reg;
    logic [AW-1:0] addr;
    logic [15:0]   exp;
  } item_t;

  item_t sb[$];
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // monitor: pops one expected item per low phase and compares it
  always @(negedge clk) begin
    item_t it;
    logic [15:0] got;
    #1;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      if (it.is_reg) begin
        rd_addr = it.addr;
        #1;
        got = {4'h0, rd_data};
      end else begin
        got = {pin_oe, pin_out};
      end
      n_chk++;
      if (got !== it.exp) begin
        n_err++;
        $display("FAIL %s: actual=%h expected=%h", it.req, got, it.exp);
      end
    end
  end

  task automatic drain();
    while (sb.size() != 0) @(posedge clk);
  endtask

  task automatic exp_reg(input string r, input logic [AW-1:0] a, input logic [11:0] e);
    sb.push_back('{r, 1'b1, a, {4'h0, e}});
    drain();
  endtask

  task automatic exp_pins(input string r, input logic [7:0] oe, input logic [7:0] o);
    sb.push_back('{r, 1'b0, '0, {oe, o}});
    drain();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pins(input logic [7:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic por_pulse();
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; gpio_out = 8'h5A; gpio_oe = 8'hFF; pin_in = 8'h00;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    exp_reg("R1 enable", 2'd0, 12'h000);
    exp_reg("R1 lock", 2'd1, 12'h000);
    exp_reg("R1 func0", 2'd2, 12'h000);
    exp_reg("R1 func1", 2'd3, 12'h000);
    exp_pins("R1 pins", 8'hFF, 8'h5A);

    // R12 function set, group disabled
    wr(2'd2, 12'h0E8);
    exp_reg("R7 func0 write", 2'd2, 12'h0E8);
    pins(8'h03);
    exp_pins("R12 disabled group", 8'hFF, 8'h5A);

    // R2 majority table
    wr(2'd0, 12'h001);
    exp_reg("R7 enable write", 2'd0, 12'h001);
    exp_pins("R2 majority 011", 8'hF8, 8'h5A);
    pins(8'h04);
    exp_pins("R2 majority 100", 8'hF8, 8'h52);

    // R4 table depending on input 0 only
    wr(2'd2, 12'h0AA);
    pins(8'h01);
    exp_pins("R4 in0-only one", 8'hFE, 8'h5A);
    pins(8'h00);
    exp_pins("R4 in0-only zero", 8'hFE, 8'h52);

    // R3 xor / xnor
    wr(2'd2, 12'h100);
    pins(8'h03);
    exp_pins("R3 xor 11", 8'hFC, 8'h52);
    pins(8'h01);
    exp_pins("R3 xor 01", 8'hFC, 8'h5A);
    wr(2'd2, 12'h200);
    pins(8'h03);
    exp_pins("R3 xnor 11", 8'hFC, 8'h5A);
    pins(8'h06);
    exp_pins("R3 xnor in2 ignored", 8'hFC, 8'h52);

    // R5 cascade: majority into xor, intermediate hidden
    wr(2'd2, 12'h0E8);
    wr(2'd3, 12'h500);
    wr(2'd0, 12'h003);
    pins(8'h23);
    exp_pins("R5 cascade 1^1", 8'hD8, 8'h5A);
    pins(8'h03);
    exp_pins("R5 cascade 1^0", 8'hD8, 8'hDA);
    pins(8'h20);
    exp_pins("R6 mid hidden", 8'hD8, 8'hDA);

    // R6 intermediate driven
    wr(2'd2, 12'h8E8);
    pins(8'h00);
    exp_pins("R6 mid driven 0", 8'hD8, 8'h52);
    pins(8'h03);
    exp_pins("R6 mid driven 1", 8'hD8, 8'hDA);

    // R8 lock group 0
    wr(2'd1, 12'h001);
    exp_reg("R8 lock set", 2'd1, 12'h001);
    wr(2'd2, 12'h0AA);
    exp_reg("R8 func0 frozen", 2'd2, 12'h8E8);
    wr(2'd0, 12'h000);
    exp_reg("R8 enable bit0 frozen", 2'd0, 12'h001);
    wr(2'd3, 12'h123);
    exp_reg("R8 func1 writable", 2'd3, 12'h123);

    // R9 second lock write ignored
    wr(2'd1, 12'h003);
    exp_reg("R9 lock once", 2'd1, 12'h001);
    wr(2'd3, 12'h000);
    exp_reg("R9 func1 still open", 2'd3, 12'h000);

    // R10 external reset gated by allow bit
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    exp_reg("R10 no allow keeps lock", 2'd1, 12'h001);
    wr(2'd0, 12'h800);
    exp_reg("R10 allow set, bit0 locked", 2'd0, 12'h801);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    exp_reg("R10 lock cleared", 2'd1, 12'h000);
    exp_reg("R10 enable untouched", 2'd0, 12'h801);
    exp_reg("R10 func0 untouched", 2'd2, 12'h8E8);
    wr(2'd1, 12'h002);
    exp_reg("R9 lock reopened", 2'd1, 12'h002);

    // R11 power-on reset clears all
    por_pulse();
    exp_reg("R11 lock", 2'd1, 12'h000);
    exp_reg("R11 enable", 2'd0, 12'h000);
    exp_reg("R11 func0", 2'd2, 12'h000);
    exp_pins("R11 pins", 8'hFF, 8'h5A);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule